// File: doc/BRIEF.md
# Two-Wire Serial Memory Read Engine

This block is a bus target on a two-wire serial bus (clock line plus open-drain data line) that gives a bus controller read access to a 4096-byte internal array. The clock and data lines are brought into the system clock domain and their edges are detected there. The block recognises START and STOP conditions and compares the target address against a fixed type code and three strap pins. It acknowledges the bytes it accepts and shifts data bytes out.

A single 12-bit word-address counter is kept across transactions. A controller positions it with a write-direction transaction that carries two address bytes and no data. Three kinds of read follow from it. A read with no address phase continues from the counter. A repeated START after the address bytes gives a random read. Acknowledging each returned byte streams consecutive locations and wraps past the top of the array. A synchronous preload port fills the array so that the returned data can be compared against a known image.

Top module: `i2c_eeprom_rd`

## Requirements
- R1: After a START, the first byte is the target address: bits 7..1 must equal binary 1010 followed by `dev_sel[2:0]`, and bit 0 is the direction (1 = read). On a match the block pulls the data line low during the ninth clock. On a mismatch it leaves the line released for that clock and for every clock after it, until the next START.
- R2: In the write direction, the block acknowledges two further bytes. The low 4 bits of the first byte and all 8 bits of the second byte form the new counter value {hi[3:0], lo}. The upper 4 bits of the first byte are ignored.
- R3: Each byte sent in a read is the array content at the counter. The counter then advances by one, and 4095 is followed by 0.
- R4: A read-direction address with no address phase before it returns the byte after the last one transferred.
- R5: An acknowledge (data low) from the controller after a data byte makes the block send the next byte. A not-acknowledge makes it release the data line and stay silent until START or STOP.
- R6: After reset, while idle, and after an address mismatch, the block never drives the data line.
- R7: A STOP returns the block to idle and leaves the counter unchanged.
- R8: The block changes its data-line drive only while the clock line is low. Incoming bits are taken on the rising clock edge.
- R9: A START or repeated START at any point restarts target-address reception. Any address byte accepted before it does not load the counter.
- R10: In the write direction, bytes after the two address bytes are not acknowledged, and the array content is unchanged.
- R11: A write on the preload port (`pre_we` high) stores `pre_data` at `pre_addr`, one byte per system clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | Pull data line low when 1 |
| dev_sel | input | 3 | Strapped device-select bits of the target address |
| pre_we | input | 1 | Preload write strobe |
| pre_addr | input | 12 | Preload byte address |
| pre_data | input | 8 | Preload byte |

## Verification
A wrong counter value shows at the ports in the first data byte of the next read. A current-address read right after each STOP therefore exposes an increment, load or wrap error within one transaction. A wrong state shows as a missing or extra acknowledge on the ninth clock of the byte where the state diverged, or as data driven where the line should be high. The bench samples every ninth clock and reads back released lines, so such errors show up within one byte time. Drive changes during a high clock are seen at the raw bus pins as soon as they happen.

// File: rtl/i2c_rd_pkg.sv
package i2c_rd_pkg;
    localparam logic [3:0] DEV_TYPE = 4'b1010;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RX,
        S_ACK,
        S_TX,
        S_MACK,
        S_WAIT
    } st_e;

    typedef enum logic [1:0] {
        PH_DEV,
        PH_AHI,
        PH_ALO,
        PH_DATA
    } ph_e;
endpackage

// File: rtl/i2c_bus_sync.sv
// Brings scl/sda into clk domain and derives edge and bus condition pulses.
// STAGES must be at least 2.
module i2c_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_sh_q, sda_sh_q;
    logic              scl_p_q, sda_p_q;
    logic              scl_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh_q <= '1;
            sda_sh_q <= '1;
            scl_p_q  <= 1'b1;
            sda_p_q  <= 1'b1;
        end else begin
            scl_sh_q <= {scl_sh_q[STAGES-2:0], scl_i};
            sda_sh_q <= {sda_sh_q[STAGES-2:0], sda_i};
            scl_p_q  <= scl_sh_q[STAGES-1];
            sda_p_q  <= sda_sh_q[STAGES-1];
        end
    end

    assign scl_now   = scl_sh_q[STAGES-1];
    assign sda_s     = sda_sh_q[STAGES-1];
    assign scl_rise  = scl_now & ~scl_p_q;
    assign scl_fall  = ~scl_now & scl_p_q;
    assign start_det = scl_now & scl_p_q & sda_p_q & ~sda_s;
    assign stop_det  = scl_now & scl_p_q & ~sda_p_q & sda_s;
endmodule

// File: rtl/i2c_rd_mem.sv
// Synchronous byte array: one read port for the engine, one preload write port.
module i2c_rd_mem #(
    parameter int AW = 12,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] arr [DEPTH];

    always_ff @(posedge clk) begin
        if (we) arr[waddr] <= wdata;
        rdata <= arr[raddr];
    end
endmodule

// File: rtl/i2c_eeprom_rd.sv
module i2c_eeprom_rd
    import i2c_rd_pkg::*;
#(
    parameter int AW          = 12,
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe,
    input  logic [2:0]    dev_sel,
    input  logic          pre_we,
    input  logic [AW-1:0] pre_addr,
    input  logic [DW-1:0] pre_data
);
    localparam int HI_W = AW - DW;
    localparam int BC_W = $clog2(DW + 1);
    localparam logic [BC_W-1:0] BC_FULL = BC_W'(DW);

    typedef struct packed {
        st_e             st;
        ph_e             ph;
        logic [BC_W-1:0] bc;
        logic [DW-1:0]   sh;
        logic [HI_W-1:0] hi;
        logic [AW-1:0]   addr;
        logic            rw;
        logic            mack;
        logic            oe;
    } regs_t;

    regs_t         r_q, r_d;
    logic          sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [DW-1:0] rdata;
    logic          dev_hit;
    st_e           st_q;
    logic [AW-1:0] addr_q;

    i2c_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_rd_mem #(.AW(AW), .DW(DW)) u_mem (
        .clk(clk), .we(pre_we), .waddr(pre_addr), .wdata(pre_data),
        .raddr(r_q.addr), .rdata(rdata)
    );

    assign dev_hit = (r_q.sh[DW-1:1] == {DEV_TYPE, dev_sel});

    always_comb begin
        r_d = r_q;
        if (start_det) begin
            r_d.st = S_RX;
            r_d.ph = PH_DEV;
            r_d.bc = '0;
            r_d.oe = 1'b0;
        end else if (stop_det) begin
            r_d.st = S_IDLE;
            r_d.oe = 1'b0;
        end else begin
            case (r_q.st)
                S_RX: begin
                    if (scl_rise) begin
                        r_d.sh = {r_q.sh[DW-2:0], sda_s};
                        r_d.bc = r_q.bc + 1'b1;
                    end else if (scl_fall && r_q.bc == BC_FULL) begin
                        case (r_q.ph)
                            PH_DEV: begin
                                if (dev_hit) begin
                                    r_d.rw = r_q.sh[0];
                                    r_d.oe = 1'b1;
                                    r_d.st = S_ACK;
                                end else begin
                                    r_d.st = S_WAIT;
                                end
                            end
                            PH_AHI: begin
                                r_d.hi = r_q.sh[HI_W-1:0];
                                r_d.oe = 1'b1;
                                r_d.st = S_ACK;
                            end
                            PH_ALO: begin
                                r_d.addr = {r_q.hi, r_q.sh};
                                r_d.oe   = 1'b1;
                                r_d.st   = S_ACK;
                            end
                            default: r_d.st = S_WAIT;
                        endcase
                    end
                end
                S_ACK: begin
                    if (scl_fall) begin
                        if (r_q.ph == PH_DEV && r_q.rw) begin
                            r_d.sh   = rdata;
                            r_d.oe   = ~rdata[DW-1];
                            r_d.bc   = BC_W'(1);
                            r_d.addr = AW'(r_q.addr + 1'b1);
                            r_d.st   = S_TX;
                        end else begin
                            r_d.oe = 1'b0;
                            r_d.bc = '0;
                            r_d.st = S_RX;
                            case (r_q.ph)
                                PH_DEV:  r_d.ph = PH_AHI;
                                PH_AHI:  r_d.ph = PH_ALO;
                                default: r_d.ph = PH_DATA;
                            endcase
                        end
                    end
                end
                S_TX: begin
                    if (scl_fall) begin
                        if (r_q.bc == BC_FULL) begin
                            r_d.oe = 1'b0;
                            r_d.st = S_MACK;
                        end else begin
                            r_d.sh = {r_q.sh[DW-2:0], 1'b0};
                            r_d.oe = ~r_q.sh[DW-2];
                            r_d.bc = r_q.bc + 1'b1;
                        end
                    end
                end
                S_MACK: begin
                    if (scl_rise) begin
                        r_d.mack = ~sda_s;
                    end else if (scl_fall) begin
                        if (r_q.mack) begin
                            r_d.sh   = rdata;
                            r_d.oe   = ~rdata[DW-1];
                            r_d.bc   = BC_W'(1);
                            r_d.addr = AW'(r_q.addr + 1'b1);
                            r_d.st   = S_TX;
                        end else begin
                            r_d.oe = 1'b0;
                            r_d.st = S_WAIT;
                        end
                    end
                end
                default: r_d.oe = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: S_IDLE, ph: PH_DEV, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_oe = r_q.oe;
    assign st_q   = r_q.st;
    assign addr_q = r_q.addr;
endmodule

// File: rtl/i2c_rd_chk.sv
module i2c_rd_chk
    import i2c_rd_pkg::*;
#(
    parameter int AW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_i,
    input logic          sda_oe,
    input st_e           st,
    input logic [AW-1:0] addr,
    input logic          start_det,
    input logic          stop_det
);
    p_drive_scl_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_i);

    p_quiet_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE || st == S_WAIT) |-> !sda_oe);

    p_stop_keeps_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> $stable(addr));

    p_start_restarts_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (st == S_RX));

    p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(st) == S_ACK || $past(st) == S_MACK) && addr != $past(addr))
        |-> (addr == AW'($past(addr) + 1'b1)));
endmodule

bind i2c_eeprom_rd i2c_rd_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
    .st(st_q), .addr(addr_q), .start_det(start_det), .stop_det(stop_det)
);

// File: tb/sim_i2c_eeprom_rd.sv
module sim_i2c_eeprom_rd;
    localparam int AW = 12;
    localparam int DW = 8;
    localparam int N  = 1 << AW;
    localparam int H  = 10;
    localparam int Q  = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          scl_r = 1'b1;
    logic          msda = 1'b1;
    logic          sda_line;
    logic          sda_oe;
    logic [2:0]    dev_sel = 3'b101;
    logic          pre_we = 1'b0;
    logic [AW-1:0] pre_addr = '0;
    logic [DW-1:0] pre_data = '0;

    int total = 0;
    int bad = 0;
    int hi_viol = 0;
    bit done = 0;
    logic [7:0] ref_mem [N];
    logic [7:0] exp_q [$];
    logic [7:0] got_q [$];
    string      tag_q [$];

    always #2 clk = ~clk;
    assign sda_line = msda & ~sda_oe;

    i2c_eeprom_rd #(.AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_r), .sda_i(sda_line),
        .sda_oe(sda_oe), .dev_sel(dev_sel), .pre_we(pre_we),
        .pre_addr(pre_addr), .pre_data(pre_data)
    );

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_start;
        msda = 1'b1; wt(H);
        scl_r = 1'b1; wt(H);
        msda = 1'b0; wt(H);
        scl_r = 1'b0; wt(Q);
    endtask

    task automatic bus_stop;
        msda = 1'b0; wt(H);
        scl_r = 1'b1; wt(H);
        msda = 1'b1; wt(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            msda = b[i]; wt(H);
            scl_r = 1'b1; wt(H);
            scl_r = 1'b0; wt(Q);
        end
        msda = 1'b1; wt(H);
        scl_r = 1'b1; wt(H / 2);
        ack = (sda_line == 1'b0);
        wt(H / 2);
        scl_r = 1'b0; wt(Q);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        msda = 1'b1;
        for (int i = 0; i < 8; i++) begin
            wt(H);
            scl_r = 1'b1; wt(H / 2);
            b = {b[6:0], sda_line};
            wt(H / 2);
            scl_r = 1'b0; wt(Q);
        end
        msda = give_ack ? 1'b0 : 1'b1; wt(H);
        scl_r = 1'b1; wt(H);
        scl_r = 1'b0; wt(Q);
        msda = 1'b1;
    endtask

    // driver side: queue expectation, then fetch the byte
    task automatic read_exp(input string tag, input int a, input bit give_ack);
        logic [7:0] b;
        exp_q.push_back(ref_mem[a]);
        tag_q.push_back(tag);
        recv_byte(give_ack, b);
        got_q.push_back(b);
    endtask

    task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo, input string tag);
        bit ack;
        bus_start;
        send_byte({4'b1010, dev_sel, 1'b0}, ack); check({tag, " dev ack"}, ack, 1);
        send_byte(hi, ack);                       check({tag, " hi ack"}, ack, 1);
        send_byte(lo, ack);                       check({tag, " lo ack"}, ack, 1);
    endtask

    task automatic rd_addr(input string tag);
        bit ack;
        bus_start;
        send_byte({4'b1010, dev_sel, 1'b1}, ack); check({tag, " rd ack"}, ack, 1);
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            wait (got_q.size() > 0);
            check(tag_q.pop_front(), got_q.pop_front(), exp_q.pop_front());
        end
    end

    // R8 at the pins: drive must not move while clock line is high
    initial begin
        logic prev = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && sda_oe != prev && scl_r) hi_viol++;
            prev = sda_oe;
        end
    end

    initial begin
        for (int c = 0; c < 200000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bit ack;
        logic [7:0] b;
        for (int i = 0; i < N; i++) ref_mem[i] = 8'((i * 37) + (i >> 8));
        wt(4);
        rst_n = 1'b1;
        wt(2);
        check("R6 reset drive", sda_oe, 0);

        // R11 preload
        for (int i = 0; i < N; i++) begin
            pre_we = 1'b1; pre_addr = AW'(i); pre_data = ref_mem[i];
            wt(1);
        end
        pre_we = 1'b0;
        wt(4);

        // R1 R2 random read, upper hi bits ignored -> 0x123
        set_addr(8'hF1, 8'h23, "R1 R2");
        rd_addr("R1");
        read_exp("R2 R3 R11 random", 'h123, 0);
        bus_stop;

        // R4 current read after STOP (R7)
        rd_addr("R4");
        read_exp("R4 R7 current", 'h124, 0);
        bus_stop;

        // R3 R5 sequential with wrap
        set_addr(8'h0F, 8'hFE, "R3");
        rd_addr("R5");
        read_exp("R5 seq0", 'hFFE, 1);
        read_exp("R5 seq1", 'hFFF, 1);
        read_exp("R3 wrap", 'h000, 1);
        read_exp("R5 seq3 nack", 'h001, 0);
        wt(H);
        check("R5 released after nack", sda_line, 1);
        recv_byte(0, b);
        check("R5 silent after nack", b, 8'hFF);
        bus_stop;

        rd_addr("R4");
        read_exp("R4 R7 after wrap", 'h002, 0);
        bus_stop;

        // R1 mismatch
        dev_sel = 3'b101;
        bus_start;
        send_byte(8'hA3, ack);
        check("R1 mismatch no ack", ack, 0);
        recv_byte(0, b);
        check("R6 silent after mismatch", b, 8'hFF);
        bus_stop;
        rd_addr("R1");
        read_exp("R1 R6 counter untouched", 'h003, 0);
        bus_stop;

        // R10 data byte in write direction
        set_addr(8'h00, 8'h10, "R10");
        send_byte(8'h55, ack);
        check("R10 data byte no ack", ack, 0);
        bus_stop;
        rd_addr("R10");
        read_exp("R10 array unchanged", 'h010, 0);
        bus_stop;

        // R9 repeated START before low address byte
        bus_start;
        send_byte({4'b1010, dev_sel, 1'b0}, ack); check("R9 dev ack", ack, 1);
        send_byte(8'h02, ack);                    check("R9 hi ack", ack, 1);
        rd_addr("R9");
        read_exp("R9 counter not loaded", 'h011, 0);
        bus_stop;

        wt(20);
        check("R8 drive changes with clock high", hi_viol, 0);
        wait (got_q.size() == 0);
        wt(4);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule